// File: doc/BRIEF.md
# Address Decoder Open-Fault Sequencer

This block is a built-in self-test sequencer for an embedded memory. It looks for open faults in the memory's address decoder, not for bitcell defects. Each address of a 2^N-word array in turn becomes the base address. The block first writes a seed word to the base. It then walks a one-hot mask across the N address bits. At each mask position it writes the complemented seed to the single-bit neighbour `base ^ mask` and reads the base straight back. A decoder with an open line makes the neighbour write land on the base, and the read-back then no longer matches the seed.

A one-cycle `start` pulse latches the seed and launches the run. The block issues exactly one memory access per clock until it has covered the whole array. It then raises `done` and holds it until the next start. The first read-back mismatch records the base address and mask, sets `err` and stops the run. An access counter on the block's ports lets a user check the exact length of the test.

Top module: `decflt_gen`

## Requirements
- R1: While `rst` is high and after it falls, with no start, `mem_we`, `mem_re`, `busy`, `done` and `err` are 0 and `acc_count` is 0.
- R2: For each base address, the first access is a write (`mem_we`=1) of the latched seed to the base address.
- R3: Each neighbour write of `~seed` to `base ^ mask` is followed on the next access by a read (`mem_re`=1) of the base address.
- R4: The mask is one-hot. It starts at bit 0 and moves one bit towards the MSB after each read-back. The group for a base ends with the read that follows the write using bit N-1, so each base takes 1+2N accesses.
- R5: Base addresses are visited in order 0, 1, …, 2^N-1. A clean run makes exactly (1+2N)·2^N accesses, and `acc_count` shows that number once `done` rises.
- R6: While the run is active, an access occurs on every clock with no idle cycle. `mem_we` and `mem_re` are never high together.
- R7: Read data is compared with the seed one cycle after the read strobe. The first mismatch sets `err`, latches `fail_base` (the base address) and `fail_mask` (the mask in use), and ends the run with `done` high. `err` and both fail fields then stay stable until the next start.
- R8: `done` stays high until the next `start`. A `start` pulse while `busy` is high has no effect: the access sequence continues unchanged and is not restarted.
- R9: The seed is sampled at start. Changes on the `seed` input during a run do not affect the written data or the compare value.
- R10: A new start after an error clears `err` and `acc_count` and runs the full sequence again from base 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that latches the seed and begins a run |
| seed | input | DW | Data pattern written to each base address |
| mem_rdata | input | DW | Memory read data, valid the cycle after `mem_re` |
| mem_addr | output | AW | Memory address (registered) |
| mem_wdata | output | DW | Memory write data (registered) |
| mem_we | output | 1 | Write strobe (registered) |
| mem_re | output | 1 | Read strobe (registered) |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, held until next start |
| err | output | 1 | A read-back mismatch was seen |
| fail_base | output | AW | Base address of the first mismatch |
| fail_mask | output | AW | One-hot mask in use at the first mismatch |
| acc_count | output | CW | Number of memory accesses issued since start |

## Verification
The bench builds the block with AW=4 and DW=8. A clean run is then 144 accesses, short enough for the bench to compare every access against a model of the order computed in the bench, including the mask wrap at bit 3 and the last base 15. The memory model can alias a write to a second address. An alias on bit 2 (write to 1 also hits 5) must be reported as base 5, mask 0100. An alias on the top bit (write to 2 also hits 10) must be reported as base 10, mask 1000. This covers a fault in the middle of the mask walk and one at its end.

// File: rtl/decflt_pkg.sv
package decflt_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_WBASE,
    S_WNEIGH,
    S_RBASE,
    S_DRAIN,
    S_DONE
  } seq_state_t;
endpackage

// File: rtl/decflt_mask.sv
module decflt_mask #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          shift,
  output logic [AW-1:0] mask,
  output logic          at_msb
);
  localparam logic [AW-1:0] FIRST = {{(AW-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst)        mask <= FIRST;
    else if (load)  mask <= FIRST;
    else if (shift) mask <= {mask[AW-2:0], 1'b0};
  end

  assign at_msb = mask[AW-1];

  AST_MASK_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot(mask)); // R4
endmodule

// File: rtl/decflt_seq.sv
module decflt_seq
  import decflt_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [DW-1:0] seed,
  input  logic          halt,
  output logic          launch,
  output logic          req_we,
  output logic          req_re,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_wdata,
  output logic [AW-1:0] req_mask,
  output logic [DW-1:0] seed_q,
  output logic          busy,
  output logic          fin
);
  localparam logic [AW-1:0] LAST_BASE = {AW{1'b1}};

  seq_state_t    st;
  logic [AW-1:0] base;
  logic [AW-1:0] mask;
  logic          at_msb;
  logic          drain;
  logic          mask_load;
  logic          mask_shift;

  assign launch     = start && (st == S_IDLE || st == S_DONE);
  assign mask_load  = launch || (st == S_RBASE && at_msb);
  assign mask_shift = (st == S_RBASE) && !at_msb;

  decflt_mask #(.AW(AW)) u_mask (
    .clk   (clk),
    .rst   (rst),
    .load  (mask_load),
    .shift (mask_shift),
    .mask  (mask),
    .at_msb(at_msb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      base   <= '0;
      seed_q <= '0;
      drain  <= 1'b0;
    end else begin
      case (st)
        S_IDLE, S_DONE: begin
          if (start) begin
            st     <= S_WBASE;
            base   <= '0;
            seed_q <= seed;
          end
        end
        S_WBASE:  st <= halt ? S_DONE : S_WNEIGH;
        S_WNEIGH: st <= halt ? S_DONE : S_RBASE;
        S_RBASE: begin
          if (halt) st <= S_DONE;
          else if (!at_msb) st <= S_WNEIGH;
          else if (base == LAST_BASE) begin
            st    <= S_DRAIN;
            drain <= 1'b0;
          end else begin
            base <= base + 1'b1;
            st   <= S_WBASE;
          end
        end
        S_DRAIN: begin
          if (halt || drain) st <= S_DONE;
          else drain <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    req_we    = (st == S_WBASE) || (st == S_WNEIGH);
    req_re    = (st == S_RBASE);
    req_addr  = (st == S_WNEIGH) ? (base ^ mask) : base;
    req_wdata = (st == S_WNEIGH) ? ~seed_q : seed_q;
    req_mask  = mask;
    busy      = (st != S_IDLE) && (st != S_DONE);
    fin       = (st == S_DONE);
  end

  AST_READ_AFTER_NEIGH: assert property (@(posedge clk) disable iff (rst)
    (st == S_RBASE) |-> ($past(st) == S_WNEIGH)); // R3
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (st == S_DONE && !start) |=> (st == S_DONE)); // R8
  AST_BASE_FIXED_IN_GROUP: assert property (@(posedge clk) disable iff (rst)
    (st == S_WNEIGH) |=> $stable(base)); // R2
endmodule

// File: rtl/decflt_check.sv
module decflt_check #(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          rd_issued,
  input  logic [AW-1:0] rd_addr,
  input  logic [AW-1:0] rd_mask,
  input  logic [DW-1:0] expect_data,
  input  logic [DW-1:0] rdata,
  output logic          err,
  output logic [AW-1:0] fail_base,
  output logic [AW-1:0] fail_mask
);
  logic          pend;
  logic [AW-1:0] pend_addr;
  logic [AW-1:0] pend_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend      <= 1'b0;
      pend_addr <= '0;
      pend_mask <= '0;
    end else begin
      pend      <= rd_issued;
      pend_addr <= rd_addr;
      pend_mask <= rd_mask;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      err       <= 1'b0;
      fail_base <= '0;
      fail_mask <= '0;
    end else if (pend && !err && (rdata != expect_data)) begin
      err       <= 1'b1;
      fail_base <= pend_addr;
      fail_mask <= pend_mask;
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err && !clear) |=> err); // R7
  AST_FAIL_STABLE: assert property (@(posedge clk) disable iff (rst)
    (err && !clear) |=> ($stable(fail_base) && $stable(fail_mask))); // R7
endmodule

// File: rtl/decflt_tally.sv
module decflt_tally #(
  parameter int CW    = 16,
  parameter int LIMIT = 100
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          inc,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (inc)     cnt <= cnt + 1'b1;
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    (cnt <= CW'(LIMIT))); // R5
endmodule

// File: rtl/decflt_gen.sv
module decflt_gen #(
  parameter int AW = 10,
  parameter int DW = 32,
  parameter int CW = AW + $clog2(2 * AW + 1) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [DW-1:0] seed,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          mem_re,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [AW-1:0] fail_base,
  output logic [AW-1:0] fail_mask,
  output logic [CW-1:0] acc_count
);
  localparam int TOTAL = (1 + 2 * AW) * (2 ** AW);

  logic          launch;
  logic          req_we, req_re;
  logic [AW-1:0] req_addr, req_mask;
  logic [DW-1:0] req_wdata, seed_q;
  logic [AW-1:0] mask_o;

  decflt_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .seed     (seed),
    .halt     (err),
    .launch   (launch),
    .req_we   (req_we),
    .req_re   (req_re),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .req_mask (req_mask),
    .seed_q   (seed_q),
    .busy     (busy),
    .fin      (done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we    <= 1'b0;
      mem_re    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mask_o    <= '0;
    end else begin
      mem_we    <= req_we;
      mem_re    <= req_re;
      mem_addr  <= req_addr;
      mem_wdata <= req_wdata;
      mask_o    <= req_mask;
    end
  end

  decflt_check #(.AW(AW), .DW(DW)) u_check (
    .clk        (clk),
    .rst        (rst),
    .clear      (launch),
    .rd_issued  (mem_re),
    .rd_addr    (mem_addr),
    .rd_mask    (mask_o),
    .expect_data(seed_q),
    .rdata      (mem_rdata),
    .err        (err),
    .fail_base  (fail_base),
    .fail_mask  (fail_mask)
  );

  decflt_tally #(.CW(CW), .LIMIT(TOTAL)) u_tally (
    .clk  (clk),
    .rst  (rst),
    .clear(launch),
    .inc  (mem_we | mem_re),
    .cnt  (acc_count)
  );

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re)); // R6
endmodule

// File: tb/decflt_gen_bench.sv
module decflt_gen_bench;
  localparam int AW    = 4;
  localparam int DW    = 8;
  localparam int CW    = AW + $clog2(2 * AW + 1) + 1;
  localparam int GRP   = 1 + 2 * AW;
  localparam int WORDS = 2 ** AW;
  localparam int TOTAL = GRP * WORDS;

  logic          clk = 0;
  logic          rst = 1;
  logic          start = 0;
  logic [DW-1:0] seed = '0;
  logic [DW-1:0] mem_rdata;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_we, mem_re, busy, done, err;
  logic [AW-1:0] fail_base, fail_mask;
  logic [CW-1:0] acc_count;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  decflt_gen #(.AW(AW), .DW(DW), .CW(CW)) u_decflt_gen (
    .clk(clk), .rst(rst), .start(start), .seed(seed), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .busy(busy), .done(done), .err(err), .fail_base(fail_base),
    .fail_mask(fail_mask), .acc_count(acc_count)
  );

  // memory model with optional write alias (decoder open fault)
  logic [DW-1:0] mem [WORDS];
  logic          alias_en = 0;
  logic [AW-1:0] alias_src = '0, alias_dst = '0;

  always_ff @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      if (alias_en && mem_addr == alias_src) mem[alias_dst] <= mem_wdata;
    end
    if (mem_re) mem_rdata <= mem[mem_addr];
  end

  // access-order monitor against a model computed here
  logic [DW-1:0] exp_seed = '0;
  bit  mon_on = 0;
  int  mon_k = 0, mon_bad = 0, cyc = 0, first_cyc = -1, last_cyc = -1;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (mon_on && (mem_we || mem_re)) begin
      int b, r;
      logic [AW-1:0] ea;
      logic [DW-1:0] ed;
      logic ew;
      b = mon_k / GRP;
      r = mon_k % GRP;
      if (r == 0) begin ew = 1; ea = AW'(b); ed = exp_seed; end
      else if (r % 2 == 1) begin ew = 1; ea = AW'(b) ^ AW'(1 << ((r - 1) / 2)); ed = ~exp_seed; end
      else begin ew = 0; ea = AW'(b); ed = '0; end
      if (mem_we != ew || mem_re != !ew || mem_addr != ea || (ew && mem_wdata != ed)) begin
        if (mon_bad == 0)
          $display("FAIL R2/R3/R4 access %0d: we=%0b addr=%0d data=%0h expected we=%0b addr=%0d data=%0h",
                   mon_k, mem_we, mem_addr, mem_wdata, ew, ea, ed);
        mon_bad <= mon_bad + 1;
      end
      if (first_cyc < 0) first_cyc <= cyc;
      last_cyc <= cyc;
      mon_k <= mon_k + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [DW-1:0] s);
    @(negedge clk);
    seed  = s;
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 4000 && !done; i++) @(negedge clk);
  endtask

  task automatic mon_arm(input logic [DW-1:0] s);
    exp_seed  = s;
    mon_k     = 0;
    mon_bad   = 0;
    first_cyc = -1;
    last_cyc  = -1;
    mon_on    = 1;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(!mem_we && !mem_re && !busy && !done && !err, "R1 in reset", {mem_we, mem_re, busy, done, err}, 0);
    rst = 0;
    repeat (2) @(negedge clk);
    chk(!mem_we && !mem_re && !busy && !done && !err, "R1 after reset", {mem_we, mem_re, busy, done, err}, 0);
    chk(acc_count == 0, "R1 counter", acc_count, 0);
  endtask

  task automatic t_clean(input logic [DW-1:0] s, input bit wiggle_seed, input bit poke_start);
    alias_en = 0;
    mon_arm(s);
    pulse_start(s);
    chk(busy, "R8 busy after start", busy, 1);
    if (wiggle_seed) seed = ~s;  // R9
    if (poke_start) begin
      repeat (40) @(negedge clk);
      start = 1;  // R8 start while busy
      @(negedge clk);
      start = 0;
    end
    wait_done();
    mon_on = 0;
    chk(done, "R5 run finished", done, 1);
    chk(mon_bad == 0, "R2 R3 R4 R9 access order", mon_bad, 0);
    chk(mon_k == TOTAL, "R5 access total", mon_k, TOTAL);
    chk(acc_count == CW'(TOTAL), "R5 acc_count", acc_count, TOTAL);
    chk(last_cyc - first_cyc == TOTAL - 1, "R6 no idle cycles", last_cyc - first_cyc, TOTAL - 1);
    chk(!err, "R7 no error on clean array", err, 0);
    repeat (10) @(negedge clk);
    chk(done && !busy, "R8 done held", {done, busy}, 2);
  endtask

  task automatic t_alias(input logic [AW-1:0] src, input logic [AW-1:0] dst,
                         input logic [AW-1:0] eb, input logic [AW-1:0] em);
    alias_src = src;
    alias_dst = dst;
    alias_en  = 1;
    pulse_start(8'h3C);
    wait_done();
    chk(done && err, "R7 error halts run", {done, err}, 3);
    chk(fail_base == eb, "R7 fail_base", fail_base, eb);
    chk(fail_mask == em, "R7 fail_mask", fail_mask, em);
    chk(acc_count < CW'(TOTAL), "R7 run stopped early", acc_count, TOTAL);
    repeat (5) @(negedge clk);
    chk(err && fail_base == eb && fail_mask == em, "R7 error fields stable", fail_base, eb);
  endtask

  task automatic t_restart();
    alias_en = 0;
    mon_arm(8'hA5);
    pulse_start(8'hA5);
    chk(!err && acc_count < 3, "R10 err and count cleared", {err, acc_count}, 0);
    wait_done();
    mon_on = 0;
    chk(!err && acc_count == CW'(TOTAL), "R10 full rerun", acc_count, TOTAL);
    chk(mon_bad == 0, "R10 rerun order from base 0", mon_bad, 0);
  endtask

  initial begin
    for (int i = 0; i < WORDS; i++) mem[i] = '0;
    t_reset();
    t_clean(8'h5A, 0, 0);
    t_clean(8'hF0, 1, 1);
    t_clean(8'h00, 0, 0);
    t_alias(4'd1, 4'd5, 4'd5, 4'b0100);
    t_alias(4'd2, 4'd10, 4'd10, 4'b1000);
    t_restart();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule